// File: doc/BRIEF.md
# Windowed Vertical Sync Divider

This block generates the field-rate reset for a monochrome raster from a clock enable that pulses twice per horizontal line. It counts half-lines and restarts its count on a separated vertical sync pulse. A pulse restarts the count only when it lands inside the currently allowed reset window. The count at which an accepted pulse lands tells the block whether the incoming field rate is 60 Hz or 50 Hz.

A saturating confidence score rises by one for every accepted pulse. It falls by one for every rejected pulse and for every field that ends without a pulse. While the score is low the divider uses a wide search window. Once the score reaches its ceiling the divider switches to a narrow window that fits the detected standard. If a pulse is missing in narrow mode, the divider restarts itself at the end of the window. The block also drives a gate that blanks the horizontal phase detector around the vertical retrace.

Top module: `vsync_window_divider`

## Requirements
- R1: While `rst_n` is low, and on the clock after it is released, `vreset`, `mode50` and `narrow` are 0 and `atf_gate` is 1. The half-line count and the confidence score are 0.
- R2: A rising edge on `vsync_in` is resynchronised and used once, at the next `hl_tick`. A level held high over several half-lines counts as a single pulse.
- R3: In wide mode, a pulse seen at a half-line count from 488 to 628 inclusive is accepted. `vreset` then goes high for the one clock after that tick and the count restarts at 0. A pulse seen at any other count is rejected and does not restart the count.
- R4: When wide mode accepts a pulse at a count below 576, `mode50` becomes 0 (60 Hz). When the count is 576 or higher, `mode50` becomes 1 (50 Hz).
- R5: In wide mode, if no pulse is accepted, the divider restarts by itself at count 628, so a free-running field lasts 629 half-lines.
- R6: The confidence score goes up by 1 on every accepted pulse. It goes down by 1 on every rejected pulse and on every restart caused by a missing pulse. It never goes below 0 or above 15.
- R7: `narrow` goes to 1 on the tick at which the score reaches 15.
- R8: In narrow mode the window is counts 522 to 528 when `mode50`=0, and counts 622 to 628 when `mode50`=1. A pulse seen outside this window is rejected and does not restart the count.
- R9: In narrow mode, if no pulse is accepted by the last count of the window, the divider restarts at that count.
- R10: `narrow` returns to 0 on the tick at which the score drops below 10.
- R11: `atf_gate` is high from the restart until the count reaches 10 (`mode50`=1) or 12 (`mode50`=0). In narrow mode it is also high from the first count of the narrow window until the restart.
- R12: `mode50` changes only on a pulse that is accepted in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_tick | input | 1 | Clock enable, one pulse per half-line |
| vsync_in | input | 1 | Separated vertical sync, asynchronous |
| vreset | output | 1 | One-clock restart / ramp-start pulse |
| mode50 | output | 1 | 1 = 50 Hz standard, 0 = 60 Hz |
| narrow | output | 1 | 1 = narrow reset window in use |
| atf_gate | output | 1 | Phase-detector blanking gate |

## Verification
The stimulus starts with a field that has no pulse at all, which shows the forced restart at 629 half-lines. Next comes a steady 60 Hz train that builds confidence up to the narrow switch. In narrow mode the bench gives early pulses, missing pulses and late pulses. These separate a restart at the end of the window from one caused by a pulse, and show the fall back to wide mode at the score threshold. Single pulses at counts 487, 488, 575 and 576 probe the edges of the wide window and the split between the two standards. A 50 Hz lock, followed by a pulse at the 60 Hz position, shows that the mode is held while the divider is in narrow mode. One sync level is held high across several half-lines to show that it is used only once.

// File: rtl/vswd_pkg.sv
package vswd_pkg;

  // Outcome of one half-line tick, as seen by the divider
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ACCEPT = 2'd1,
    EV_REJECT = 2'd2,
    EV_MISS   = 2'd3
  } sync_ev_e;

  // Pick between two constants by a select bit
  function automatic int pick(input logic sel, input int when_one, input int when_zero);
    return sel ? when_one : when_zero;
  endfunction

  // Inclusive range test on plain integers
  function automatic logic in_span(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Saturating up/down step of the confidence score
  function automatic int sat_step(input int cur, input logic up, input logic down, input int top);
    int r;
    r = cur;
    if (up && (cur < top))
      r = cur + 1;
    else if (down && (cur > 0))
      r = cur - 1;
    return r;
  endfunction

  // Lower edge of the active reset window
  function automatic int win_low(input logic nar, input logic m50,
                                 input int wide_lo, input int n50_lo, input int n60_lo);
    return nar ? pick(m50, n50_lo, n60_lo) : wide_lo;
  endfunction

  // Upper edge of the active reset window (also the forced restart count)
  function automatic int win_high(input logic nar, input logic m50,
                                  input int wide_hi, input int n50_hi, input int n60_hi);
    return nar ? pick(m50, n50_hi, n60_hi) : wide_hi;
  endfunction

endpackage

// File: rtl/vswd_sync_edge.sv
module vswd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic tick,
  output logic trig
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;
  logic          pend_q;
  logic          rise_w;

  // Resynchroniser: one flop per stage
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign rise_w = chain[LAST] & ~prev_q;

  // Remember an edge until the next half-line tick consumes it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= chain[LAST];
      if (tick)        pend_q <= 1'b0;
      else if (rise_w) pend_q <= 1'b1;
    end
  end

  assign trig = tick & (pend_q | rise_w);

endmodule

// File: rtl/vswd_window.sv
module vswd_window
  import vswd_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int WIDE_LO   = 488,
  parameter int WIDE_HI   = 628,
  parameter int SPLIT     = 576,
  parameter int N60_LO    = 522,
  parameter int N60_HI    = 528,
  parameter int N50_LO    = 622,
  parameter int N50_HI    = 628,
  parameter int ATF50_END = 10,
  parameter int ATF60_END = 12
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             narrow,
  input  logic             mode50,
  output logic             in_win,
  output logic             at_end,
  output logic             late,
  output logic             atf_on
);
  int c;
  int lo;
  int hi;
  int nlo;
  int aend;

  always_comb begin
    c      = int'(cnt);
    lo     = win_low(narrow, mode50, WIDE_LO, N50_LO, N60_LO);
    hi     = win_high(narrow, mode50, WIDE_HI, N50_HI, N60_HI);
    nlo    = pick(mode50, N50_LO, N60_LO);
    aend   = pick(mode50, ATF50_END, ATF60_END);
    in_win = in_span(c, lo, hi);
    at_end = (c == hi);
    late   = (c >= SPLIT);
    atf_on = (c < aend) || (narrow && (c >= nlo));
  end

endmodule

// File: rtl/vswd_confidence.sv
module vswd_confidence
  import vswd_pkg::*;
#(
  parameter int CONF_W      = 4,
  parameter int LEAVE_BELOW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up,
  input  logic              down,
  output logic [CONF_W-1:0] conf,
  output logic              narrow
);
  localparam int TOP = (1 << CONF_W) - 1;

  logic [CONF_W-1:0] conf_q;
  logic [CONF_W-1:0] conf_nxt;
  logic              narrow_q;
  logic              narrow_nxt;

  always_comb begin
    conf_nxt   = CONF_W'(sat_step(int'(conf_q), up, down, TOP));
    narrow_nxt = narrow_q;
    if (!narrow_q && (int'(conf_nxt) == TOP))
      narrow_nxt = 1'b1;
    else if (narrow_q && (int'(conf_nxt) < LEAVE_BELOW))
      narrow_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conf_q   <= '0;
      narrow_q <= 1'b0;
    end else begin
      conf_q   <= conf_nxt;
      narrow_q <= narrow_nxt;
    end
  end

  assign conf   = conf_q;
  assign narrow = narrow_q;

endmodule

// File: rtl/vsync_window_divider.sv
module vsync_window_divider
  import vswd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int CONF_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WIDE_LO     = 488,
  parameter int WIDE_HI     = 628,
  parameter int SPLIT       = 576,
  parameter int N60_LO      = 522,
  parameter int N60_HI      = 528,
  parameter int N50_LO      = 622,
  parameter int N50_HI      = 628,
  parameter int LEAVE_BELOW = 10,
  parameter int ATF50_END   = 10,
  parameter int ATF60_END   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hl_tick,
  input  logic vsync_in,
  output logic vreset,
  output logic mode50,
  output logic narrow,
  output logic atf_gate
);
  // Named internal events, observed by the bound checker
  logic [CNT_W-1:0]  cnt_q;
  logic [CONF_W-1:0] conf_w;
  logic              trig_evt;
  logic              accept_evt;
  logic              reject_evt;
  logic              miss_evt;
  logic              restart_w;
  logic              in_win_w;
  logic              at_end_w;
  logic              late_w;
  logic              atf_w;
  logic              mode50_q;
  logic              vreset_q;
  logic              narrow_w;
  sync_ev_e          ev;

  vswd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (vsync_in),
    .tick     (hl_tick),
    .trig     (trig_evt)
  );

  vswd_window #(
    .CNT_W     (CNT_W),
    .WIDE_LO   (WIDE_LO),
    .WIDE_HI   (WIDE_HI),
    .SPLIT     (SPLIT),
    .N60_LO    (N60_LO),
    .N60_HI    (N60_HI),
    .N50_LO    (N50_LO),
    .N50_HI    (N50_HI),
    .ATF50_END (ATF50_END),
    .ATF60_END (ATF60_END)
  ) u_win (
    .cnt    (cnt_q),
    .narrow (narrow_w),
    .mode50 (mode50_q),
    .in_win (in_win_w),
    .at_end (at_end_w),
    .late   (late_w),
    .atf_on (atf_w)
  );

  // Classify the current tick
  always_comb begin
    ev = EV_NONE;
    if (hl_tick) begin
      if (trig_evt && in_win_w) ev = EV_ACCEPT;
      else if (trig_evt)        ev = EV_REJECT;
      else if (at_end_w)        ev = EV_MISS;
    end
  end

  assign accept_evt = (ev == EV_ACCEPT);
  assign reject_evt = (ev == EV_REJECT);
  assign miss_evt   = (ev == EV_MISS);
  assign restart_w  = accept_evt | miss_evt;

  vswd_confidence #(
    .CONF_W      (CONF_W),
    .LEAVE_BELOW (LEAVE_BELOW)
  ) u_conf (
    .clk    (clk),
    .rst_n  (rst_n),
    .up     (accept_evt),
    .down   (reject_evt | miss_evt),
    .conf   (conf_w),
    .narrow (narrow_w)
  );

  // Half-line counter, standard flag and restart pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      mode50_q <= 1'b0;
      vreset_q <= 1'b0;
    end else begin
      vreset_q <= restart_w;
      if (hl_tick) begin
        if (restart_w) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
      if (accept_evt && !narrow_w)
        mode50_q <= late_w;
    end
  end

  assign vreset   = vreset_q;
  assign mode50   = mode50_q;
  assign narrow   = narrow_w;
  assign atf_gate = atf_w;

endmodule

// File: rtl/vswd_checker.sv
module vswd_checker #(
  parameter int CNT_W       = 10,
  parameter int CONF_W      = 4,
  parameter int WIDE_HI     = 628,
  parameter int N60_LO      = 522,
  parameter int N60_HI      = 528,
  parameter int N50_LO      = 622,
  parameter int N50_HI      = 628,
  parameter int LEAVE_BELOW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              trig,
  input logic              accept,
  input logic              miss,
  input logic [CNT_W-1:0]  cnt,
  input logic [CONF_W-1:0] conf,
  input logic              narrow,
  input logic              mode50,
  input logic              vreset
);
  localparam logic [CONF_W-1:0] TOP = '1;

  // R2
  trig_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> tick);

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vreset |-> (cnt == '0));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= WIDE_HI);

  // R6
  conf_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (conf != TOP)) |=> (conf == $past(conf) + 1'b1));

  // R6
  conf_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && (conf != '0)) |=> (conf == $past(conf) - 1'b1));

  // R7
  narrow_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(narrow) |-> (conf == TOP));

  // R10
  narrow_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(narrow) |-> (int'(conf) < LEAVE_BELOW));

  // R8
  narrow_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && accept) |->
      (mode50 ? (int'(cnt) >= N50_LO && int'(cnt) <= N50_HI)
              : (int'(cnt) >= N60_LO && int'(cnt) <= N60_HI)));

  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |=> $stable(mode50));

endmodule

bind vsync_window_divider vswd_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (hl_tick),
  .trig   (trig_evt),
  .accept (accept_evt),
  .miss   (miss_evt),
  .cnt    (cnt_q),
  .conf   (conf_w),
  .narrow (narrow_w),
  .mode50 (mode50_q),
  .vreset (vreset_q)
);

// File: tb/tb_vsync_window_divider.sv
module tb_vsync_window_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hl_tick = 1'b0;
  logic vsync_in = 1'b0;
  logic vreset, mode50, narrow, atf_gate;

  int tests = 0;
  int fails = 0;
  int clocks = 0;
  bit finished = 0;

  // behavioural reference state
  int m_cnt = 0;
  int m_conf = 0;
  bit m_nar = 0;
  bit m_m50 = 0;
  bit m_vres = 0;
  bit m_trig = 0;
  int hold_left = 0;

  vsync_window_divider dut (
    .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .vsync_in(vsync_in),
    .vreset(vreset), .mode50(mode50), .narrow(narrow), .atf_gate(atf_gate)
  );

  always #10 clk = ~clk;

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      clocks++;
      if (clocks > 195000 && !finished) begin
        fails++;
        $display("FAIL watchdog: actual %0d clocks, expected fewer", clocks);
        report();
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference: one half-line step
  task automatic model_tick(input bit t);
    int lo, hi;
    bit acc, miss;
    if (m_nar) begin
      lo = m_m50 ? 622 : 522;
      hi = m_m50 ? 628 : 528;
    end else begin
      lo = 488;
      hi = 628;
    end
    acc  = t && (m_cnt >= lo) && (m_cnt <= hi);
    miss = !t && (m_cnt == hi);
    if (acc) begin
      if (m_conf < 15) m_conf++;
      if (!m_nar) m_m50 = (m_cnt >= 576);
    end else if (t || miss) begin
      if (m_conf > 0) m_conf--;
    end
    if (!m_nar && m_conf == 15) m_nar = 1;
    else if (m_nar && m_conf < 10) m_nar = 0;
    m_vres = acc || miss;
    m_cnt = m_vres ? 0 : m_cnt + 1;
  endtask

  function automatic bit exp_atf();
    int e;
    e = m_m50 ? 10 : 12;
    return (m_cnt < e) || (m_nar && (m_cnt >= (m_m50 ? 622 : 522)));
  endfunction

  task automatic cyc();
    @(posedge clk);
    if (hl_tick) model_tick(m_trig);
    else m_vres = 0;
    #2;
    chk(vreset == m_vres, "R3 R5 R9 vreset", vreset, m_vres);
    chk(mode50 == m_m50, "R4 R12 mode50", mode50, m_m50);
    chk(narrow == m_nar, "R6 R7 R10 narrow", narrow, m_nar);
    chk(atf_gate == exp_atf(), "R11 atf_gate", atf_gate, exp_atf());
  endtask

  task automatic half_line(input bit vs, input bit t);
    vsync_in = vs;
    hl_tick = 0;
    cyc(); cyc(); cyc();
    hl_tick = 1;
    m_trig = t;
    cyc();
    hl_tick = 0;
  endtask

  // run until the divider restarts; target<0 means no pulse; returns half-lines
  task automatic run_field(input int target, input int hold, output int len);
    bit t, vs;
    len = 0;
    do begin
      t = (m_cnt == target);
      if (t) hold_left = hold;
      vs = (hold_left > 0);
      half_line(vs, t);
      if (hold_left > 0) hold_left--;
      len++;
    end while (!m_vres && len < 700);
  endtask

  initial begin
    int len;
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    chk(vreset == 0, "R1 vreset", vreset, 0);
    chk(mode50 == 0, "R1 mode50", mode50, 0);
    chk(narrow == 0, "R1 narrow", narrow, 0);
    chk(atf_gate == 1, "R1 atf_gate", atf_gate, 1);
    rst_n = 1;
    cyc();
    chk(vreset == 0 && narrow == 0, "R1 after release", vreset, 0);

    // R5 free-running wide field, R6 floor at zero
    run_field(-1, 1, len);
    chk(len == 629, "R5 free-run length", len, 629);

    // R7 60 Hz lock
    for (int i = 1; i <= 15; i++) begin
      run_field(524, 1, len);
      chk(len == 525, "R3 accepted field length", len, 525);
      if (i == 14) chk(narrow == 0, "R7 not yet narrow", narrow, 0);
    end
    chk(narrow == 1, "R7 narrow after 15 accepts", narrow, 1);
    chk(mode50 == 0, "R4 60 Hz detected", mode50, 0);
    run_field(524, 1, len);
    run_field(524, 1, len);

    // R8 early pulse rejected, R9 restart at window end
    run_field(500, 1, len);
    chk(len == 529, "R8 early pulse ignored", len, 529);
    run_field(-1, 1, len);
    chk(len == 529, "R9 missing pulse restart", len, 529);
    run_field(500, 1, len);
    chk(narrow == 1, "R10 still narrow at 10", narrow, 1);
    run_field(500, 1, len);
    chk(narrow == 0, "R10 left narrow below 10", narrow, 0);
    chk(len == 629, "R10 wide end after leaving", len, 629);

    // R3 pulse before the wide window ignored
    run_field(400, 1, len);
    chk(len == 629, "R3 pulse at 400 ignored", len, 629);

    // R2 level held over three half-lines
    run_field(490, 3, len);
    chk(len == 491, "R2 held pulse accepted", len, 491);
    run_field(524, 1, len);
    chk(len == 525, "R2 held level used once", len, 525);

    // R3/R4 wide window edges and standard split
    run_field(487, 1, len);
    chk(len == 629, "R3 count 487 rejected", len, 629);
    run_field(488, 1, len);
    chk(len == 489, "R3 count 488 accepted", len, 489);
    chk(mode50 == 0, "R4 488 gives 60 Hz", mode50, 0);
    run_field(576, 1, len);
    chk(mode50 == 1, "R4 576 gives 50 Hz", mode50, 1);
    run_field(575, 1, len);
    chk(mode50 == 0, "R4 575 gives 60 Hz", mode50, 0);

    // R7/R8 50 Hz lock
    for (int i = 0; i < 16 && !m_nar; i++) run_field(624, 1, len);
    chk(narrow == 1 && mode50 == 1, "R7 50 Hz narrow lock", {narrow, mode50}, 3);
    run_field(523, 1, len);
    chk(len == 629, "R8 60 Hz pulse ignored in 50 Hz window", len, 629);
    chk(mode50 == 1, "R12 mode held in narrow", mode50, 1);
    run_field(625, 1, len);
    chk(len == 626, "R8 625 accepted", len, 626);

    finished = 1;
    report();
    $finish;
  end

endmodule